// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Controller

This block is the control logic of a multi-output clock buffer. It decides, per differential output pair and for one single-ended reference output, whether the output toggles, rests at a fixed level, or floats. Its inputs are a combined power-good/power-down pin, one active-low enable pin per pair, a PLL lock flag, two board straps and a few register values that arrive as plain ports.

The first rising edge of power-good does two things. It captures the bus address strap and the three-level spread strap, and it starts the device. After that the same pin is a power-down control: low parks the outputs, high resumes them. Every asynchronous control passes through a two-flop synchronizer in the reference clock domain. The gate enables are registered on the falling clock edge, so a gated clock can only start or stop while it is low. Each output also reports a 2-bit status: 00 running, 01 parked low, 10 parked high, 11 high-impedance.

Top module: `clkout_pwr_ctrl`

## Requirements
- R1: The straps are captured on the first rising edge of the synchronized power-good and stay unchanged, whatever the pins do, until `rst_n` is asserted. `straps_valid` rises at the same time.
- R2: The captured address strap selects the 7-bit address: 0 gives 7'h68 (1101000) and 1 gives 7'h6A (1101010).
- R3: The spread strap is coded 2'b00 = low, 2'b01 = mid and 2'b1x = high. These decode to `ss_code` 2'b00 (off), 2'b01 (-0.25%) and 2'b10 (-0.5%) respectively.
- R4: Pair i runs (`dif_en[i]`=1, status 2'b00) only when all four hold: power-good is high, `reg_oe[i]`=1, `oe_n_in[i]`=0 and lock is high. Pin high disables the pair. A register bit of 0 disables it at any pin level.
- R5: A disabled pair drives `dif_p`=`reg_park[1]` and `dif_n`=`reg_park[0]`. Its status is 2'b10 when `reg_park[1]`=1 and 2'b01 otherwise. This includes power-down, when power-good is low.
- R6: While the lock flag is low, every pair is disabled.
- R7: The reference is high-impedance (`ref_oe`=0, status 2'b11, `ref_out`=0) until power-good first rises. After that, while power-good is low, the reference is parked low (status 2'b01) unless `reg_ref_pd_run`=1, in which case it runs (status 2'b00).
- R8: Once started, the reference runs while power-good is high.
- R9: A change on `pg_in`, `oe_n_in` or `pll_lock_in` reaches the synchronized level at the second rising edge. `ref_oe` follows at that edge, the straps at the third.
- R10: `dif_en` and the internal reference enable change only on a falling edge of `clk`, so the gated clocks never produce a runt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the clock being gated |
| rst_n | input | 1 | Active-low asynchronous reset |
| pg_in | input | 1 | Power-good / power-down pin (asynchronous) |
| oe_n_in | input | NOUT | Active-low enable pin per pair (asynchronous) |
| pll_lock_in | input | 1 | PLL lock flag (asynchronous) |
| strap_addr | input | 1 | Address strap |
| strap_ss | input | 2 | Three-level spread strap, coded as in R3 |
| reg_oe | input | NOUT | Register enable bit per pair |
| reg_park | input | 2 | Parked level: [1] true leg, [0] complement leg |
| reg_ref_pd_run | input | 1 | Keep the reference running in power-down |
| bus_addr | output | 7 | Captured bus address |
| ss_code | output | 2 | Captured spread code |
| straps_valid | output | 1 | Straps have been captured |
| dif_en | output | NOUT | Gate enable per pair, registered on the falling edge |
| dif_p | output | NOUT | True leg of each pair |
| dif_n | output | NOUT | Complement leg of each pair |
| dif_st | output | 2*NOUT | Status per pair, two bits each, pair i at [2i+1:2i] |
| ref_out | output | 1 | Single-ended reference output |
| ref_oe | output | 1 | Reference driver enable (0 = high-impedance) |
| ref_st | output | 2 | Reference status |

## Verification
The bench changes inputs just after a falling edge, so each result falls due at a known edge:
- `ref_oe` after the second rising edge.
- The pair enables and statuses after the falling edge that follows that rising edge.
- The straps after the third rising edge.

The latency scenario samples 1 ns after each of those edges and also confirms that `dif_en` still holds its old value just after the second rising edge. The other scenarios wait four full cycles before sampling, and they sample while the clock is high, so a parked-high leg cannot be mistaken for a toggling one.

// File: rtl/clkout_pwr_ctrl.sv
`timescale 1ns/1ps
module clkout_pwr_ctrl #(
  parameter int         NOUT      = 6,
  parameter logic [6:0] ADDR_BASE = 7'h68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_in,
  input  logic [NOUT-1:0]   oe_n_in,
  input  logic              pll_lock_in,
  input  logic              strap_addr,
  input  logic [1:0]        strap_ss,
  input  logic [NOUT-1:0]   reg_oe,
  input  logic [1:0]        reg_park,
  input  logic              reg_ref_pd_run,
  output logic [6:0]        bus_addr,
  output logic [1:0]        ss_code,
  output logic              straps_valid,
  output logic [NOUT-1:0]   dif_en,
  output logic [NOUT-1:0]   dif_p,
  output logic [NOUT-1:0]   dif_n,
  output logic [2*NOUT-1:0] dif_st,
  output logic              ref_out,
  output logic              ref_oe,
  output logic [1:0]        ref_st
);
  localparam int SW = NOUT + 2;
  localparam logic [1:0] ST_RUN = 2'b00, ST_LOW = 2'b01, ST_HIGH = 2'b10, ST_HIZ = 2'b11;

  logic [SW-1:0]   sync1, sync2;
  logic            pg_s, lock_s, pg_seen, started, adr_q, ref_en;
  logic [1:0]      ss_q;
  logic [NOUT-1:0] oe_n_s, run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {pg_in, pll_lock_in, oe_n_in};
      sync2 <= sync1;
    end

  assign pg_s   = sync2[SW-1];
  assign lock_s = sync2[SW-2];
  assign oe_n_s = sync2[NOUT-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pg_seen <= 1'b0;
      adr_q   <= 1'b0;
      ss_q    <= 2'b00;
    end else if (pg_s && !pg_seen) begin
      pg_seen <= 1'b1;
      adr_q   <= strap_addr;
      ss_q    <= strap_ss[1] ? 2'b10 : {1'b0, strap_ss[0]};
    end

  assign started      = pg_seen | pg_s;
  assign straps_valid = pg_seen;
  assign bus_addr     = ADDR_BASE | {5'b0, adr_q, 1'b0};
  assign ss_code      = ss_q;
  assign run          = (pg_s && lock_s) ? (reg_oe & ~oe_n_s) : '0;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      dif_en <= '0;
      ref_en <= 1'b0;
    end else begin
      dif_en <= run;
      ref_en <= started & (pg_s | reg_ref_pd_run);
    end

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    assign dif_p[i]          = dif_en[i] ? clk  : reg_park[1];
    assign dif_n[i]          = dif_en[i] ? ~clk : reg_park[0];
    assign dif_st[2*i +: 2]  = dif_en[i] ? ST_RUN : (reg_park[1] ? ST_HIGH : ST_LOW);
  end

  assign ref_oe  = started;
  assign ref_out = ref_oe & ref_en & clk;
  assign ref_st  = !ref_oe ? ST_HIZ : (ref_en ? ST_RUN : ST_LOW);

  AST_STRAPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pg_seen) |-> ($stable(adr_q) && $stable(ss_q))); // R1
  AST_ADDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pg_seen |-> (bus_addr == 7'h68 || bus_addr == 7'h6A)); // R2
  AST_SS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ss_code != 2'b11); // R3
  AST_EN_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (|dif_en) |-> (lock_s && pg_s)); // R6
  AST_REF_HIZ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !ref_en); // R7
endmodule

// File: tb/clkout_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module clkout_pwr_ctrl_bench;
  localparam int N = 6;
  logic clk = 0, rst_n = 0, pg_in = 0, pll_lock_in = 0, strap_addr = 0, reg_ref_pd_run = 0;
  logic [N-1:0] oe_n_in = '0, reg_oe = '1;
  logic [1:0] strap_ss = 2'b00, reg_park = 2'b00;
  logic [6:0] bus_addr;
  logic [1:0] ss_code, ref_st;
  logic straps_valid, ref_out, ref_oe;
  logic [N-1:0] dif_en, dif_p, dif_n;
  logic [2*N-1:0] dif_st;
  int errors = 0, checks = 0;

  clkout_pwr_ctrl #(.NOUT(N)) u_clkout_pwr_ctrl (.*);

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*N-1:0] model_st(logic pg, logic lock, logic [N-1:0] r, logic [N-1:0] pin, logic [1:0] pk);
    logic [2*N-1:0] s;
    for (int i = 0; i < N; i++)
      s[2*i +: 2] = (pg && lock && r[i] && !pin[i]) ? 2'b00 : (pk[1] ? 2'b10 : 2'b01);
    return s;
  endfunction

  function automatic logic [N-1:0] model_en(logic pg, logic lock, logic [N-1:0] r, logic [N-1:0] pin);
    return (pg && lock) ? (r & ~pin) : '0;
  endfunction

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0; pg_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    settle();
  endtask

  task automatic t_reset_state();
    chk("R7 ref status hi-z after reset", ref_st, 2'b11);
    chk("R7 ref_oe low after reset", ref_oe, 0);
    chk("R1 straps not valid after reset", straps_valid, 0);
    chk("R4 pairs disabled after reset", dif_en, 0);
    chk("R5 parked low status after reset", dif_st, model_st(0, 0, reg_oe, oe_n_in, reg_park));
  endtask

  task automatic t_first_pg_latency();
    strap_addr = 1; strap_ss = 2'b01; pll_lock_in = 1; reg_oe = '1; oe_n_in = '0;
    @(negedge clk); pg_in = 1;
    @(posedge clk); @(posedge clk); #1;
    chk("R10 dif_en unchanged at rising edge", dif_en, 0);
    chk("R9 ref_oe at second edge", ref_oe, 1);
    @(negedge clk); #1;
    chk("R9 dif_en after following falling edge", dif_en, {N{1'b1}});
    chk("R10 gated output low while clk low", dif_p, 0);
    @(posedge clk); #1;
    chk("R1 straps valid at third edge", straps_valid, 1);
    chk("R2 address strap 1", bus_addr, 7'h6A);
    chk("R3 mid strap", ss_code, 2'b01);
    chk("R8 ref running", ref_st, 2'b00);
    chk("R8 ref toggles high", ref_out, 1);
  endtask

  task automatic t_enable_patterns();
    logic [N-1:0] pins [3] = '{6'b101010, 6'b000000, 6'b110011};
    logic [N-1:0] regs [3] = '{6'b111111, 6'b001111, 6'b010101};
    for (int k = 0; k < 3; k++) begin
      oe_n_in = pins[k]; reg_oe = regs[k]; reg_park = 2'b00;
      settle();
      chk("R4 pair status per pin/reg", dif_st, model_st(1, 1, regs[k], pins[k], 2'b00));
      chk("R4 gate enables per pin/reg", dif_en, model_en(1, 1, regs[k], pins[k]));
    end
    reg_oe = '1; oe_n_in = '0;
    settle();
  endtask

  task automatic t_lock_loss();
    pll_lock_in = 0; reg_park = 2'b01;
    settle();
    chk("R6 unlocked disables all", dif_en, 0);
    chk("R5 parked comp leg high", dif_n, {N{1'b1}});
    pll_lock_in = 1; reg_park = 2'b00;
    settle();
    chk("R6 relock runs all", dif_en, {N{1'b1}});
  endtask

  task automatic t_power_down();
    reg_park = 2'b10; reg_ref_pd_run = 0;
    @(negedge clk); pg_in = 0;
    settle();
    chk("R5 power-down park high status", dif_st, model_st(0, 1, reg_oe, oe_n_in, 2'b10));
    chk("R5 true leg parked high", dif_p, {N{1'b1}});
    chk("R5 comp leg parked low", dif_n, 0);
    chk("R7 ref parked low in power-down", ref_st, 2'b01);
    chk("R7 ref_out low in power-down", ref_out, 0);
    chk("R7 ref_oe stays after start", ref_oe, 1);
    reg_ref_pd_run = 1;
    settle();
    chk("R7 ref keeps running by register", ref_st, 2'b00);
    strap_addr = 0; strap_ss = 2'b10;
    @(negedge clk); pg_in = 1;
    settle();
    chk("R1 address held after power-down exit", bus_addr, 7'h6A);
    chk("R1 spread held after power-down exit", ss_code, 2'b01);
    chk("R4 power-down exit resumes", dif_en, {N{1'b1}});
    reg_park = 2'b00; reg_ref_pd_run = 0;
  endtask

  task automatic t_restrap(logic a, logic [1:0] ss, logic [6:0] ea, logic [1:0] ec);
    strap_addr = a; strap_ss = ss;
    do_reset();
    chk("R1 straps cleared by reset", straps_valid, 0);
    @(negedge clk); pg_in = 1;
    settle();
    chk("R2 address per strap", bus_addr, ea);
    chk("R3 spread per strap", ss_code, ec);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    t_reset_state();
    t_first_pg_latency();
    t_enable_patterns();
    t_lock_loss();
    t_power_down();
    t_restrap(0, 2'b10, 7'h68, 2'b10);
    t_restrap(1, 2'b00, 7'h6A, 2'b00);
    t_restrap(0, 2'b11, 7'h68, 2'b10);
    finish_run();
  end
endmodule